// File: doc/BRIEF.md
# Memory-Mapped Keyboard and Display Terminal Controller

This block is a slave on a simple 32-bit processor load/store bus. It gives software four word registers near the top of the address space: a status/control word and a data word for an incoming keyboard channel, and the same pair for an outgoing display channel. Software either polls the Ready flag in a control word or enables an interrupt that is raised while Ready is set.

Keyboard bytes arrive on a one-cycle byte-valid strobe. The byte is latched and receiver Ready rises. A load of the receiver data word returns the byte and clears Ready. A store to the transmitter data word, when the transmitter is ready, hands the low byte to the display side on a valid/busy handshake. Transmitter Ready stays low until the display takes the byte. A byte that arrives before software has read the previous one overwrites it and sets a sticky overrun flag.

Top module: `term_io_ctrl`

## Requirements
- R1: After reset, receiver Ready is 0, transmitter Ready is 1, both Interrupt Enable bits are 0, both interrupt outputs are 0, disp_valid is 0, rx_overrun is 0 and bus_rdata is 0.
- R2: Only the four word-aligned addresses BASE_ADDR+0x0 (receiver control), +0x4 (receiver data), +0x8 (transmitter control) and +0xC (transmitter data) respond; addr[1:0] must be 00. An access to any other address has no effect on any state. bus_rdata is 0 in every cycle that does not follow a read that hits.
- R3: A cycle with kb_valid=1 latches kb_byte into the receiver data word and sets receiver Ready. A read of the receiver data word returns the byte in bits 7:0 with bits 31:8 zero. bus_rdata carries the result from the clock edge that samples bus_rd until the next edge.
- R4: A read of the receiver data word clears receiver Ready at the same edge. A read of either control word changes no state.
- R5: When kb_valid=1 arrives while receiver Ready is 1 and the receiver data word is not read in that cycle, the new byte replaces the old one and rx_overrun is set. rx_overrun stays 1 until reset. When a byte arrives in the same cycle as a receiver data read, the read returns the old byte, the new byte is kept, Ready stays 1, and no overrun is flagged.
- R6: A control word reads as Ready in bit 0 and Interrupt Enable in bit 1, with bits 31:2 zero. The transmitter data word reads as 0.
- R7: A write to a control word with bus_be[0]=1 loads Interrupt Enable from bus_wdata[1]. Ready is not writable; bus_wdata[0] is ignored.
- R8: A write to the transmitter data word with bus_be[0]=1 while transmitter Ready is 1 drives disp_byte=bus_wdata[7:0] and disp_valid=1, and clears transmitter Ready, from the next edge.
- R9: disp_valid and disp_byte hold while disp_busy is 1. At the first edge where disp_valid=1 and disp_busy=0, disp_valid drops and transmitter Ready returns to 1.
- R10: A transmitter data write while transmitter Ready is 0, or with bus_be[0]=0, is ignored.
- R11: rx_irq equals receiver Interrupt Enable AND receiver Ready. tx_irq equals transmitter Interrupt Enable AND transmitter Ready. Both are levels that follow the register state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Load strobe |
| bus_wr | input | 1 | Store strobe |
| bus_wdata | input | 32 | Store data |
| bus_be | input | 4 | Byte enables of the store |
| bus_rdata | output | 32 | Load result, registered |
| kb_valid | input | 1 | Keyboard byte strobe |
| kb_byte | input | 8 | Keyboard character |
| disp_busy | input | 1 | Display cannot take the byte this cycle |
| disp_valid | output | 1 | Display byte pending |
| disp_byte | output | 8 | Character to the display |
| rx_irq | output | 1 | Receiver interrupt request, level |
| tx_irq | output | 1 | Transmitter interrupt request, level |
| rx_overrun | output | 1 | Sticky lost-character flag |

## Verification
Every register in the block updates at the edge that samples its inputs. A load result on bus_rdata, a Ready change, the display valid/byte pair and the overrun flag are therefore all due one edge after the stimulus. The interrupt outputs follow combinationally in that same cycle. The bench drives inputs on the falling edge, steps a cycle-exact reference model at the rising edge, and compares every output shortly after that edge, before the next input change. Directed sequences add fixed expected values for the same-cycle read/arrival case, writes to the Ready bits, blocked transmitter writes and unmapped addresses.

// File: rtl/term_io_pkg.sv
package term_io_pkg;
  localparam int WORD_W = 32;
  localparam int CHAR_W = 8;
  localparam int RDY_BIT = 0;
  localparam int IE_BIT = 1;
  localparam int NUM_REGS = 4;

  typedef enum logic [1:0] {
    RG_RX_CTRL = 2'd0,
    RG_RX_DATA = 2'd1,
    RG_TX_CTRL = 2'd2,
    RG_TX_DATA = 2'd3
  } term_reg_e;

  function automatic logic [WORD_W-1:0] pack_ctrl(input logic ie, input logic rdy);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RDY_BIT] = rdy;
    w[IE_BIT] = ie;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_char(input logic [CHAR_W-1:0] c);
    return {{(WORD_W-CHAR_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/term_bus_decode.sv
module term_bus_decode
  import term_io_pkg::*;
#(
  parameter logic [WORD_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic [WORD_W-1:0]   addr,
  input  logic                rd,
  input  logic                wr,
  input  logic                be0,
  output logic                hit,
  output term_reg_e           idx,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic [NUM_REGS-1:0] wr_sel
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int LOW_W = IDX_W + 2;

  assign hit = (addr[WORD_W-1:LOW_W] == BASE_ADDR[WORD_W-1:LOW_W]) && (addr[1:0] == 2'b00);
  assign idx = term_reg_e'(addr[LOW_W-1:2]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign rd_sel[g] = rd && hit && (idx == term_reg_e'(g));
    assign wr_sel[g] = wr && be0 && hit && (idx == term_reg_e'(g));
  end
endmodule

// File: rtl/term_rx_chan.sv
module term_rx_chan
  import term_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_byte,
  input  logic              data_rd,
  input  logic              ie_wr,
  input  logic              ie_val,
  output logic              rdy,
  output logic              ie,
  output logic [CHAR_W-1:0] data,
  output logic              overrun,
  output logic              irq
);
  logic lost_char;
  assign lost_char = kb_valid && rdy && !data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b0;
      ie <= 1'b0;
      data <= '0;
      overrun <= 1'b0;
    end else begin
      if (kb_valid) begin
        data <= kb_byte;
        rdy <= 1'b1;
      end else if (data_rd) begin
        rdy <= 1'b0;
      end
      if (lost_char) overrun <= 1'b1;
      if (ie_wr) ie <= ie_val;
    end
  end

  assign irq = ie && rdy;

  assert_rd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !kb_valid |=> !rdy);
  assert_arrival_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> rdy && data == $past(kb_byte));
  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_overrun_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(kb_valid) && $past(rdy));
endmodule

// File: rtl/term_tx_chan.sv
module term_tx_chan
  import term_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wr_byte,
  input  logic              ie_wr,
  input  logic              ie_val,
  input  logic              disp_busy,
  output logic              rdy,
  output logic              ie,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_byte,
  output logic              irq
);
  typedef enum logic {TX_IDLE = 1'b0, TX_PEND = 1'b1} tx_state_e;
  tx_state_e state;
  logic take, done;

  assign take = data_wr && (state == TX_IDLE);
  assign done = (state == TX_PEND) && !disp_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      disp_byte <= '0;
      ie <= 1'b0;
    end else begin
      if (take) begin
        state <= TX_PEND;
        disp_byte <= wr_byte;
      end else if (done) begin
        state <= TX_IDLE;
      end
      if (ie_wr) ie <= ie_val;
    end
  end

  assign rdy = (state == TX_IDLE);
  assign disp_valid = (state == TX_PEND);
  assign irq = ie && rdy;

  assert_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && rdy |=> disp_valid && disp_byte == $past(wr_byte));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_busy |=> disp_valid && $stable(disp_byte));
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_busy |=> rdy);
  assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !rdy |=> $stable(disp_byte));
endmodule

// File: rtl/term_io_ctrl.sv
module term_io_ctrl
  import term_io_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_be,
  output logic [31:0] bus_rdata,
  input  logic        kb_valid,
  input  logic [7:0]  kb_byte,
  input  logic        disp_busy,
  output logic        disp_valid,
  output logic [7:0]  disp_byte,
  output logic        rx_irq,
  output logic        tx_irq,
  output logic        rx_overrun
);
  logic hit;
  term_reg_e idx;
  logic [NUM_REGS-1:0] rd_sel, wr_sel;
  logic rx_rdy, rx_ie, tx_rdy, tx_ie;
  logic [CHAR_W-1:0] rx_data;
  logic [WORD_W-1:0] rd_mux;
  logic unused_bits;

  assign unused_bits = ^{bus_be[3:1], bus_wdata[WORD_W-1:CHAR_W]};

  term_bus_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .be0(bus_be[0]),
    .hit(hit), .idx(idx), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  term_rx_chan u_rx (
    .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .kb_byte(kb_byte),
    .data_rd(rd_sel[RG_RX_DATA]), .ie_wr(wr_sel[RG_RX_CTRL]), .ie_val(bus_wdata[IE_BIT]),
    .rdy(rx_rdy), .ie(rx_ie), .data(rx_data), .overrun(rx_overrun), .irq(rx_irq)
  );

  term_tx_chan u_tx (
    .clk(clk), .rst_n(rst_n), .data_wr(wr_sel[RG_TX_DATA]), .wr_byte(bus_wdata[CHAR_W-1:0]),
    .ie_wr(wr_sel[RG_TX_CTRL]), .ie_val(bus_wdata[IE_BIT]), .disp_busy(disp_busy),
    .rdy(tx_rdy), .ie(tx_ie), .disp_valid(disp_valid), .disp_byte(disp_byte), .irq(tx_irq)
  );

  always_comb begin
    unique case (idx)
      RG_RX_CTRL: rd_mux = pack_ctrl(rx_ie, rx_rdy);
      RG_RX_DATA: rd_mux = pack_char(rx_data);
      RG_TX_CTRL: rd_mux = pack_ctrl(tx_ie, tx_rdy);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd && hit) bus_rdata <= rd_mux;
    else bus_rdata <= '0;
  end

  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && hit) |=> bus_rdata == '0);
  assert_ctrl_fmt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && hit && idx != RG_RX_DATA |=> bus_rdata[WORD_W-1:2] == '0);
  assert_data_fmt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel[RG_RX_DATA] |=> bus_rdata[WORD_W-1:CHAR_W] == '0);
  assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> rx_rdy);
endmodule

// File: tb/term_io_ctrl_tb_top.sv
module term_io_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_rd = 1'b0, bus_wr = 1'b0, kb_valid = 1'b0, disp_busy = 1'b0;
  logic [3:0] bus_be = '0;
  logic [7:0] kb_byte = '0, disp_byte;
  logic disp_valid, rx_irq, tx_irq, rx_overrun;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit m_rrdy, m_rie, m_ovr, m_pend, m_tie;
  logic [7:0] m_rdat, m_tbyte;
  logic [31:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_io_ctrl #(.BASE_ADDR(BASE)) dut_i (.*);

  function automatic logic [31:0] ctrl_val(bit ie, bit rdy);
    return (32'(ie) << 1) | 32'(rdy);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2/R3/R6 rdata", bus_rdata, m_rdata);
    check("R11 rx_irq", 32'(rx_irq), 32'(m_rie & m_rrdy));
    check("R11 tx_irq", 32'(tx_irq), 32'(m_tie & !m_pend));
    check("R8 disp_valid", 32'(disp_valid), 32'(m_pend));
    if (m_pend) check("R8 disp_byte", 32'(disp_byte), 32'(m_tbyte));
    check("R5 overrun", 32'(rx_overrun), 32'(m_ovr));
  endtask

  // one bus/device cycle; called at a falling edge
  task automatic cyc(bit rd, bit wr, logic [31:0] a, logic [31:0] wd, logic [3:0] be,
                     bit kv, logic [7:0] kb, bit busy);
    bit hit, rclr;
    logic [1:0] ix;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; bus_be = be;
    kb_valid = kv; kb_byte = kb; disp_busy = busy;
    hit = (a[31:4] == BASE[31:4]) && (a[1:0] == 2'b00);
    ix = a[3:2];
    if (rd && hit)
      case (ix)
        2'd0: m_rdata = ctrl_val(m_rie, m_rrdy);
        2'd1: m_rdata = {24'h0, m_rdat};
        2'd2: m_rdata = ctrl_val(m_tie, !m_pend);
        default: m_rdata = 0;
      endcase
    else m_rdata = 0;
    rclr = rd && hit && ix == 2'd1;
    if (kv) begin
      if (m_rrdy && !rclr) m_ovr = 1;
      m_rdat = kb; m_rrdy = 1;
    end else if (rclr) m_rrdy = 0;
    if (wr && hit && be[0] && ix == 2'd0) m_rie = wd[1];
    if (wr && hit && be[0] && ix == 2'd2) m_tie = wd[1];
    if (m_pend) begin
      if (!busy) m_pend = 0;
    end else if (wr && hit && be[0] && ix == 2'd3) begin
      m_pend = 1; m_tbyte = wd[7:0];
    end
    @(posedge clk); #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic idle(bit busy = 0);
    cyc(0, 0, 0, 0, 0, 0, 0, busy);
  endtask
  task automatic rd(logic [31:0] off);
    cyc(1, 0, BASE + off, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(logic [31:0] off, logic [31:0] d, logic [3:0] be = 4'hF, bit busy = 0);
    cyc(0, 1, BASE + off, d, be, 0, 0, busy);
  endtask
  task automatic kb(logic [7:0] b);
    cyc(0, 0, 0, 0, 0, 1, b, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_rrdy = 0; m_rie = 0; m_ovr = 0; m_pend = 0; m_tie = 0;
    m_rdat = 0; m_tbyte = 0; m_rdata = 0;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 rdata", bus_rdata, 0);
    check("R1 disp_valid", 32'(disp_valid), 0);
    check("R1 irqs", {30'h0, rx_irq, tx_irq}, 0);
    check("R1 overrun", 32'(rx_overrun), 0);
    rst_n = 1;
    @(negedge clk);
    rd(0); check("R1 rx ctrl", bus_rdata, 32'h0);
    rd(8); check("R1 tx ctrl", bus_rdata, 32'h1);

    // R3 / R4 / R6 receive path
    kb(8'hA5);
    rd(0); check("R6 rx ctrl ready", bus_rdata, 32'h1);
    rd(0); check("R4 ctrl read keeps ready", bus_rdata, 32'h1);
    rd(4); check("R3 rx data", bus_rdata, 32'h0000_00A5);
    rd(0); check("R4 data read clears ready", bus_rdata, 32'h0);

    // R7 / R11 enable, ready not writable
    wr(0, 32'hFFFF_FFFF);
    rd(0); check("R7 ie set, ready ignores write", bus_rdata, 32'h2);
    check("R11 rx_irq low without ready", 32'(rx_irq), 0);
    kb(8'h3C); check("R11 rx_irq on ready", 32'(rx_irq), 1);
    wr(0, 32'h2, 4'h0); check("R7 be0=0 ignored", 32'(rx_irq), 1);
    wr(0, 32'h1); check("R11 irq drops with ie", 32'(rx_irq), 0);

    // R5 overrun and simultaneous read+arrival
    kb(8'h11);
    check("R5 overrun set", 32'(rx_overrun), 1);
    rd(4); check("R5 newest byte kept", bus_rdata, 32'h11);
    kb(8'h22);
    cyc(1, 0, BASE + 4, 0, 0, 1, 8'h33, 0);
    check("R5 same-cycle read returns old", bus_rdata, 32'h22);
    rd(0); check("R5 ready stays after same-cycle", bus_rdata, 32'h1);
    rd(4); check("R5 new byte kept", bus_rdata, 32'h33);
    idle(); check("R5 sticky", 32'(rx_overrun), 1);

    // R8 / R9 / R10 transmit path
    wr(8, 32'h2);
    check("R11 tx_irq when ready", 32'(tx_irq), 1);
    wr(12, 32'hDEAD_BE41, 4'hF, 1);
    check("R8 disp_valid", 32'(disp_valid), 1);
    check("R8 disp_byte", 32'(disp_byte), 32'h41);
    check("R11 tx_irq low when busy", 32'(tx_irq), 0);
    wr(12, 32'h55, 4'hF, 1); check("R10 write while not ready", 32'(disp_byte), 32'h41);
    idle(1); check("R9 hold while busy", 32'(disp_valid), 1);
    idle(0); check("R9 release", 32'(disp_valid), 0);
    rd(8); check("R9 ready back", bus_rdata, 32'h3);
    wr(12, 32'h77, 4'hE); check("R10 be0=0 ignored", 32'(disp_valid), 0);
    rd(12); check("R6 tx data reads zero", bus_rdata, 0);

    // R2 unmapped accesses
    cyc(0, 1, BASE + 32'h10, 32'h2, 4'hF, 0, 0, 0);
    cyc(0, 1, BASE + 32'hD, 32'h99, 4'hF, 0, 0, 0);
    check("R2 miss write ignored", 32'(disp_valid), 0);
    cyc(1, 0, BASE + 32'h1, 0, 0, 0, 0, 0); check("R2 misaligned read", bus_rdata, 0);
    cyc(1, 0, 32'h0000_0004, 0, 0, 0, 0, 0); check("R2 far read", bus_rdata, 0);

    // random mix, checked against the model each cycle
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [31:0] a;
      op = $urandom_range(0, 9);
      a = BASE + 32'($urandom_range(0, 3) * 4);
      if ($urandom_range(0, 15) == 0) a = $urandom;
      case (op)
        0, 1: cyc(1, 0, a, 0, 0, $urandom_range(0, 3) == 0, 8'($urandom), $urandom_range(0, 1));
        2, 3: cyc(0, 1, a, $urandom, 4'($urandom), $urandom_range(0, 3) == 0, 8'($urandom),
                  $urandom_range(0, 1));
        4:    cyc(0, 0, 0, 0, 0, 1, 8'($urandom), $urandom_range(0, 1));
        default: cyc(0, 0, 0, 0, 0, 0, 0, $urandom_range(0, 2) == 0);
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule